// File: doc/BRIEF.md
# Linear Copy Command Packetizer

This block turns one linear memory copy request into a stream of copy command packets for a DMA engine's command ring. A request carries a 40-bit destination address, a 40-bit source address and a length in bytes. It is taken over a valid/ready handshake. The block emits five-word packets, one 32-bit word per accepted output beat, on a valid/ready output.

The block chooses between two transfer modes. When both addresses and the length are all multiples of four, it counts in 32-bit words. Otherwise it counts in bytes. Each packet's count is limited to a fixed ceiling for its mode, and neither ceiling is a power of two, so a long copy is split into several packets. Between packets, both addresses move forward by the amount the previous packet covered.

A single-cycle completion pulse marks the end of each request. The next request is taken only once the block is idle again.

Top module: `copy_packetizer`

## Requirements
- R1: Word 0 of each packet is the header. Bits [31:28] hold the command code 0x3, bits [27:20] hold the sub-command, and bits [19:0] hold the packet count.
- R2: Word mode applies exactly when the destination address, the source address and the length are all divisible by 4. In that case the sub-command is 0x00 and the total count is the length divided by 4. In every other case the sub-command is 0x40 and the total count is the length in bytes.
- R3: A packet's count never exceeds 0xFFFF8 in word mode or 0xFFFE0 in byte mode. A request produces ceil(total count / ceiling) packets. Every packet carries the ceiling except the last, which carries what remains.
- R4: Words 1 to 4 of a packet, in this order, are:
  - destination address bits [31:0];
  - source address bits [31:0];
  - destination bits [39:32] in bits [7:0], with zeros above;
  - source bits [39:32] in bits [7:0], with zeros above.
- R5: After each packet, both addresses advance by the packet count times 4 in word mode, or by the packet count in byte mode, with carry into bits [39:32].
- R6: A request with zero length emits no words, and done_o pulses in the cycle after it is accepted.
- R7: req_ready_o is high only while no packet stream is in progress, which includes the state after reset. A request presented during a stream is not taken and produces no words.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_word_o does not change on the next cycle.
- R9: done_o is high for exactly one cycle, the cycle after the last word of the last packet is accepted, and out_valid_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Copy request present |
| req_ready_o | output | 1 | Block idle, request taken on this cycle if valid |
| req_dst_i | input | 40 | Destination byte address |
| req_src_i | input | 40 | Source byte address |
| req_len_i | input | 32 | Copy length in bytes |
| out_valid_o | output | 1 | Packet word present |
| out_ready_i | input | 1 | Downstream takes the word |
| out_word_o | output | 32 | Packet word |
| done_o | output | 1 | One-cycle pulse at the end of a request |

## Verification
The checker assumes the downstream never drops a word once it is offered. It also relies on out_ready_i being the only thing that paces the stream, so an offered word with ready low must still be offered on the next cycle. Stimulus changes inputs only on falling edges. In one scenario it holds ready low for several cycles mid-packet. In another it deliberately raises a second request while a stream is running and withdraws it before the stream ends, so that the request is never seen by an idle block.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  typedef enum logic {ST_IDLE, ST_SEND} cpk_state_e;
  localparam logic [3:0] CMD_COPY  = 4'h3;
  localparam logic [7:0] SUB_DWORD = 8'h00;
  localparam logic [7:0] SUB_BYTE  = 8'h40;
  localparam int         WORD_W    = 32;
  localparam int         HDR_CNT_W = 20;
endpackage

// File: rtl/cpk_classify.sv
module cpk_classify #(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 32
) (
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              dword_o,
  output logic [LEN_W-1:0]  count_o
);
  always_comb begin
    dword_o = (dst_i[1:0] == 2'b00) && (src_i[1:0] == 2'b00) && (len_i[1:0] == 2'b00);
    count_o = dword_o ? (len_i >> 2) : len_i;
  end
endmodule

// File: rtl/cpk_chunk.sv
module cpk_chunk #(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 20,
  parameter int DW_MAX = 'hFFFF8,
  parameter int BY_MAX = 'hFFFE0
) (
  input  logic [LEN_W-1:0]  remain_i,
  input  logic              dword_i,
  output logic [CNT_W-1:0]  chunk_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] step_o
);
  logic [LEN_W-1:0]  cap;
  logic [ADDR_W-1:0] ext;

  always_comb begin
    cap     = dword_i ? LEN_W'(DW_MAX) : LEN_W'(BY_MAX);
    last_o  = (remain_i <= cap);
    chunk_o = last_o ? remain_i[CNT_W-1:0] : cap[CNT_W-1:0];
    ext     = ADDR_W'(chunk_o);
    step_o  = dword_i ? (ext << 2) : ext;
  end
endmodule

// File: rtl/cpk_word_fmt.sv
module cpk_word_fmt
  import cpk_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 20,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              dword_i,
  input  logic [CNT_W-1:0]  chunk_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] src_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HI_W = ADDR_W - WORD_W;

  logic [HDR_CNT_W-1:0] cnt_f;
  logic [7:0]           sub_f;

  always_comb begin
    cnt_f = HDR_CNT_W'(chunk_i);
    sub_f = dword_i ? SUB_DWORD : SUB_BYTE;
    case (idx_i)
      IDX_W'(0): word_o = {CMD_COPY, sub_f, cnt_f};
      IDX_W'(1): word_o = dst_i[WORD_W-1:0];
      IDX_W'(2): word_o = src_i[WORD_W-1:0];
      IDX_W'(3): word_o = {{(WORD_W-8){1'b0}}, 8'(dst_i[ADDR_W-1:WORD_W])};
      IDX_W'(4): word_o = {{(WORD_W-8){1'b0}}, 8'(src_i[ADDR_W-1:WORD_W])};
      default:   word_o = '0;
    endcase
  end

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/copy_packetizer.sv
module copy_packetizer
  import cpk_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 20,
  parameter int DW_MAX = 'hFFFF8,
  parameter int BY_MAX = 'hFFFE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_dst_i,
  input  logic [ADDR_W-1:0] req_src_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [31:0]       out_word_o,
  output logic              done_o
);
  localparam int PKT_WORDS = 5;
  localparam int IDX_W     = $clog2(PKT_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_WORDS - 1);

  cpk_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] dst_q, src_q;
  logic [LEN_W-1:0]  remain_q;
  logic              dword_q, done_q;

  logic              cls_dword;
  logic [LEN_W-1:0]  cls_count;
  logic [CNT_W-1:0]  chunk;
  logic              chunk_last;
  logic [ADDR_W-1:0] step;
  logic              accept, fire;

  cpk_classify #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_classify (
    .dst_i   (req_dst_i),
    .src_i   (req_src_i),
    .len_i   (req_len_i),
    .dword_o (cls_dword),
    .count_o (cls_count)
  );

  cpk_chunk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .DW_MAX(DW_MAX), .BY_MAX(BY_MAX)
  ) u_chunk (
    .remain_i (remain_q),
    .dword_i  (dword_q),
    .chunk_o  (chunk),
    .last_o   (chunk_last),
    .step_o   (step)
  );

  cpk_word_fmt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_fmt (
    .idx_i   (idx_q),
    .dword_i (dword_q),
    .chunk_i (chunk),
    .dst_i   (dst_q),
    .src_i   (src_q),
    .word_o  (out_word_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_SEND);
  assign done_o      = done_q;
  assign accept      = req_valid_i & req_ready_o;
  assign fire        = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      remain_q <= '0;
      dword_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            dst_q    <= req_dst_i;
            src_q    <= req_src_i;
            dword_q  <= cls_dword;
            remain_q <= cls_count;
            idx_q    <= '0;
            if (cls_count == '0) done_q  <= 1'b1;
            else                 state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fire) begin
            if (idx_q == IDX_LAST) begin
              idx_q    <= '0;
              dst_q    <= dst_q + step;
              src_q    <= src_q + step;
              remain_q <= remain_q - LEN_W'(chunk);
              if (chunk_last) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/copy_packetizer_chk.sv
module copy_packetizer_chk #(
  parameter int IDX_W  = 3,
  parameter int DW_MAX = 'hFFFF8,
  parameter int BY_MAX = 'hFFFE0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [31:0]      out_word_o,
  input logic             done_o,
  input logic [IDX_W-1:0] idx_q,
  input logic             dword_q
);
  assert_hdr_cmd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && idx_q == '0) |->
      (out_word_o[31:28] == 4'h3) &&
      (out_word_o[27:20] == 8'h00 || out_word_o[27:20] == 8'h40));

  assert_cnt_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && idx_q == '0) |->
      (out_word_o[19:0] != 20'd0) &&
      (32'(out_word_o[19:0]) <= (dword_q ? 32'(DW_MAX) : 32'(BY_MAX))));

  assert_hi_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && idx_q >= IDX_W'(3)) |-> (out_word_o[31:8] == 24'd0));

  assert_idle_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !out_valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o);
endmodule

bind copy_packetizer copy_packetizer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_word_o  (out_word_o),
  .done_o      (done_o),
  .idx_q       (idx_q),
  .dword_q     (dword_q)
);

// File: tb/copy_packetizer_test.sv
module copy_packetizer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DWM = 'hFFFF8;
  localparam int BYM = 'hFFFE0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [39:0] req_dst_i = '0;
  logic [39:0] req_src_i = '0;
  logic [31:0] req_len_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_word_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_w [0:39];
  int n_exp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  copy_packetizer uut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_dst_i, .req_src_i,
    .req_len_i, .out_valid_o, .out_ready_i, .out_word_o, .done_o
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected stream built from R1..R5
  task automatic build_exp(input logic [39:0] dst, input logic [39:0] src, input logic [31:0] len);
    bit dw;
    logic [31:0] cnt, cap, c;
    logic [39:0] d, s;
    dw = (dst % 4 == 0) && (src % 4 == 0) && (len % 4 == 0);
    cnt = dw ? len / 4 : len;
    cap = dw ? 32'(DWM) : 32'(BYM);
    d = dst; s = src; n_exp = 0;
    while (cnt > 0 && n_exp < 36) begin
      c = (cnt > cap) ? cap : cnt;
      exp_w[n_exp]   = {4'h3, dw ? 8'h00 : 8'h40, c[19:0]};
      exp_w[n_exp+1] = d[31:0];
      exp_w[n_exp+2] = s[31:0];
      exp_w[n_exp+3] = {24'd0, d[39:32]};
      exp_w[n_exp+4] = {24'd0, s[39:32]};
      n_exp += 5;
      d = d + (dw ? 40'(c) * 4 : 40'(c));
      s = s + (dw ? 40'(c) * 4 : 40'(c));
      cnt = cnt - c;
    end
  endtask

  task automatic run_copy(input logic [39:0] dst, input logic [39:0] src, input logic [31:0] len,
                          input bit stall, input bit busy_req);
    int got = 0;
    int cyc = 0;
    bit prev_stall = 1'b0;
    logic [31:0] prev_word = '0;
    logic [7:0] pat = 8'b1011_0010;
    build_exp(dst, src, len);
    @(negedge clk_i);
    req_dst_i = dst; req_src_i = src; req_len_i = len; req_valid_i = 1'b1;
    out_ready_i = 1'b0;
    #1 chk(req_ready_o == 1'b1, "R7 idle ready", 64'(req_ready_o), 64'd1);
    while (got < n_exp && cyc < 5000) begin
      @(negedge clk_i);
      out_ready_i = stall ? pat[cyc % 8] : 1'b1;
      if (busy_req && got >= 1 && got <= 3) begin
        req_valid_i = 1'b1; req_dst_i = 40'hEE_EEEE_EEE0; req_src_i = '0; req_len_i = 32'd40;
      end else begin
        req_valid_i = 1'b0;
      end
      #1;
      if (prev_stall)
        chk(out_valid_o && out_word_o == prev_word, "R8 hold", 64'(out_word_o), 64'(prev_word));
      if (busy_req && req_valid_i)
        chk(req_ready_o == 1'b0, "R7 busy", 64'(req_ready_o), 64'd0);
      if (out_valid_o && out_ready_i) begin
        if (got < 5) chk(out_word_o == exp_w[got], (got % 5 == 0) ? "R2 R1 header" : "R4 word",
                         64'(out_word_o), 64'(exp_w[got]));
        else         chk(out_word_o == exp_w[got], (got % 5 == 0) ? "R3 header" : "R5 address",
                         64'(out_word_o), 64'(exp_w[got]));
        got++;
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_word  = out_word_o;
      cyc++;
    end
    req_valid_i = 1'b0;
    chk(got == n_exp, "R3 word count", 64'(got), 64'(n_exp));
    @(negedge clk_i); #1;
    chk(done_o == 1'b1 && out_valid_o == 1'b0, "R9 done",
        64'({done_o, out_valid_o}), 64'b10);
    @(negedge clk_i); #1;
    chk(done_o == 1'b0 && out_valid_o == 1'b0 && req_ready_o == 1'b1, "R9 R7 after",
        64'({done_o, out_valid_o, req_ready_o}), 64'b001);
    out_ready_i = 1'b0;
  endtask

  task automatic test_reset;
    #1 chk(req_ready_o == 1'b1 && out_valid_o == 1'b0 && done_o == 1'b0, "R7 reset",
           64'({req_ready_o, out_valid_o, done_o}), 64'b100);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic test_zero_len;
    @(negedge clk_i);
    req_dst_i = 40'h00_0000_1000; req_src_i = 40'h00_0000_2000; req_len_i = 32'd0;
    req_valid_i = 1'b1;
    @(negedge clk_i); req_valid_i = 1'b0; #1;
    chk(done_o == 1'b1 && out_valid_o == 1'b0 && req_ready_o == 1'b1, "R6 zero done",
        64'({done_o, out_valid_o, req_ready_o}), 64'b101);
    @(negedge clk_i); #1;
    chk(done_o == 1'b0 && out_valid_o == 1'b0, "R6 zero quiet",
        64'({done_o, out_valid_o}), 64'b00);
  endtask

  task automatic test_dword_small;   run_copy(40'h12_3456_7800, 40'hAB_0000_0010, 32'd64, 0, 0); endtask
  task automatic test_byte_addr;     run_copy(40'h00_0000_1000, 40'h00_0000_2003, 32'd13, 0, 0); endtask
  task automatic test_byte_len;      run_copy(40'h05_0000_0100, 40'h06_0000_0200, 32'd6, 0, 0); endtask
  task automatic test_byte_split;    run_copy(40'h01_FFFF_0000, 40'h02_0000_0001, 32'hFFFE7, 0, 0); endtask
  task automatic test_dword_split;   run_copy(40'h03_FFF0_0000, 40'h04_0000_0000, 32'h7FFFCC, 0, 0); endtask
  task automatic test_dword_exact;   run_copy(40'h00_1000_0000, 40'h00_2000_0000, 32'h3FFFE0, 0, 0); endtask
  task automatic test_backpressure;  run_copy(40'h7F_0000_0004, 40'h80_0000_0008, 32'h3FFFE8, 1, 0); endtask
  task automatic test_busy_ignored;  run_copy(40'h09_0000_0040, 40'h0A_0000_0080, 32'd100, 0, 1); endtask

  bit finished = 1'b0;

  initial begin
    test_reset();
    test_dword_small();
    test_byte_addr();
    test_byte_len();
    test_byte_split();
    test_dword_split();
    test_dword_exact();
    test_backpressure();
    test_zero_len();
    test_busy_ignored();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule